// File: doc/BRIEF.md
# Bank-Set Line Position Manager with Generational Promotion

This block keeps the ordering of the cache lines held in one bank set of `NUM_POS` positions. Position 0 is the slot nearest the cache controller and therefore the cheapest to reach. Lines earn their way forward one step at a time: each hit on a line moves it exactly one position closer to the controller by trading places with its nearer neighbour. Heavily used lines drift toward position 0 over many hits. Rarely used lines sink toward the far end.

New lines do not replace the far slot in place. While the set still has empty slots, a fill takes the farthest empty one and nothing leaves. Once the set is full, a fill is inserted at the middle position `NUM_POS/2`. Every line from the middle up to the second-farthest slides one place farther away. The line that was in the farthest slot leaves the set and is reported on the eviction output for one cycle.

Only one operation is accepted per cycle. A hit takes priority over a fill; a fill that arrives with a hit is refused and flagged as stalled, and the requester must present it again. The controller holds two named states. FILLING is entered at reset and stays while empty slots remain. The transition SET_COMPLETE moves it to FULL when the fill that takes position 0 is accepted. FULL stays until reset. Tag search and data movement live outside this block.

Top module: `promo_bank_set`

## Requirements
- R1: After reset every position is empty (`set_valid` all zero, all stored tags zero), `evict_valid` is low, and `fill_stall` is low while no requests are presented.
- R2: A hit at position p > 0, where positions p and p-1 both hold lines, swaps the tags at p and p-1; the new order is visible after the next rising clock edge.
- R3: A hit at position 0, at an empty position, or at a position whose nearer neighbour p-1 is empty leaves all tags and valid bits unchanged.
- R4: A fill accepted while all positions are occupied writes the new tag at position `NUM_POS/2`, moves the tags of positions `NUM_POS/2` to `NUM_POS-2` one position farther, and leaves positions below `NUM_POS/2` unchanged.
- R5: `evict_valid` is high for exactly the one cycle after a fill is accepted into a full set, with `evict_tag` equal to the tag that was at position `NUM_POS-1`; in every other cycle it is low.
- R6: A fill accepted while some positions are empty writes the tag into the highest-numbered empty position, marks it valid, and raises no eviction.
- R7: When a hit and a fill are presented in the same cycle, `fill_stall` is high in that cycle (combinationally), the hit is carried out as in R2/R3, and the fill has no effect.
- R8: A cycle with neither request present changes no tag, no valid bit and raises no eviction.
- R9: `set_tags` bits `[i*TAG_W +: TAG_W]` carry the tag at position i and `set_valid[i]` marks position i occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_req | input | 1 | Hit request for the line at `hit_pos` |
| hit_pos | input | $clog2(NUM_POS) | Position of the line that hit |
| fill_req | input | 1 | Request to bring a new line into the set |
| fill_tag | input | TAG_W | Tag of the new line |
| fill_stall | output | 1 | Fill refused this cycle because a hit was present |
| evict_valid | output | 1 | One-cycle pulse: a line left the set |
| evict_tag | output | TAG_W | Tag of the line that left |
| set_tags | output | NUM_POS*TAG_W | Tags by position, position i at `[i*TAG_W +: TAG_W]` |
| set_valid | output | NUM_POS | Occupancy by position |

## Verification
The bench goes after the hit at position 0 and the hit at an empty position: a design that promoted blindly would pull an empty slot forward or wrap the index and corrupt the far end. It fills the set to exactly full and then fills once more. A design that miscounted the empty slots would evict early or overwrite a live line, and one that replaced the far slot in place would show the new tag at the wrong position. It also presents a hit and a fill together. A design without hit priority would lose the promotion or quietly swallow the fill without raising the stall.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE       = 2'd0,
        OP_HIT        = 2'd1,
        OP_FILL_EMPTY = 2'd2,
        OP_FILL_FULL  = 2'd3
    } op_e;

    typedef enum logic {
        ST_FILLING = 1'b0,
        ST_FULL    = 1'b1
    } st_e;

endpackage

// File: rtl/pbs_op_decode.sv
module pbs_op_decode
    import pbs_pkg::*;
#(
    parameter int NUM_POS = 8,
    parameter int POS_W   = $clog2(NUM_POS),
    parameter int CNT_W   = $clog2(NUM_POS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_req,
    input  logic [POS_W-1:0]   hit_pos,
    input  logic               fill_req,
    input  logic [NUM_POS-1:0] slot_valid,
    output op_e                op,
    output logic [POS_W-1:0]   op_pos,
    output logic [POS_W-1:0]   fill_pos,
    output logic               fill_stall
);

    st_e              state, state_nxt;
    logic [CNT_W-1:0] used_cnt, used_cnt_nxt;
    logic             hit_movable;

    // a hit can only move a live line forward into a live neighbour
    always_comb begin
        hit_movable = 1'b0;
        if (int'(hit_pos) < NUM_POS && hit_pos != '0) begin
            hit_movable = slot_valid[hit_pos] && slot_valid[hit_pos - POS_W'(1)];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_FILLING;
            used_cnt <= '0;
        end else begin
            state    <= state_nxt;
            used_cnt <= used_cnt_nxt;
        end
    end

    // next state: SET_COMPLETE when the last empty slot is taken
    always_comb begin
        state_nxt    = state;
        used_cnt_nxt = used_cnt;
        unique case (state)
            ST_FILLING: begin
                if (op == OP_FILL_EMPTY) begin
                    used_cnt_nxt = used_cnt + CNT_W'(1);
                    if (int'(used_cnt) == NUM_POS - 1) begin
                        state_nxt = ST_FULL;
                    end
                end
            end
            ST_FULL: begin
                state_nxt = ST_FULL;
            end
            default: state_nxt = ST_FILLING;
        endcase
    end

    // outputs: operation selection with hit priority
    always_comb begin
        op         = OP_IDLE;
        op_pos     = hit_pos;
        fill_pos   = '0;
        fill_stall = hit_req && fill_req;
        unique case (state)
            ST_FILLING: begin
                fill_pos = POS_W'(NUM_POS - 1 - int'(used_cnt));
                if (hit_req) begin
                    if (hit_movable) op = OP_HIT;
                end else if (fill_req) begin
                    op = OP_FILL_EMPTY;
                end
            end
            ST_FULL: begin
                if (hit_req) begin
                    if (hit_movable) op = OP_HIT;
                end else if (fill_req) begin
                    op = OP_FILL_FULL;
                end
            end
            default: op = OP_IDLE;
        endcase
    end

    // R7: a stalled fill never turns into a fill operation
    assert_stall_blocks_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_stall |-> (op != OP_FILL_EMPTY && op != OP_FILL_FULL));

    // R6: once every slot is taken the set never reports room again
    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FULL |=> (state == ST_FULL && &slot_valid));

endmodule

// File: rtl/pbs_slot_store.sv
module pbs_slot_store
    import pbs_pkg::*;
#(
    parameter int NUM_POS = 8,
    parameter int TAG_W   = 8,
    parameter int POS_W   = $clog2(NUM_POS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  op_e                             op,
    input  logic [POS_W-1:0]                op_pos,
    input  logic [POS_W-1:0]                fill_pos,
    input  logic [TAG_W-1:0]                fill_tag,
    output logic [NUM_POS-1:0][TAG_W-1:0]   tags,
    output logic [NUM_POS-1:0]              valid,
    output logic                            evict_valid,
    output logic [TAG_W-1:0]                evict_tag
);

    localparam int MID = NUM_POS / 2;

    for (genvar i = 0; i < NUM_POS; i++) begin : g_slot
        logic [TAG_W-1:0] nearer_tag;
        logic [TAG_W-1:0] farther_tag;
        logic [TAG_W-1:0] tag_nxt;
        logic             val_nxt;

        if (i > 0) begin : g_has_nearer
            assign nearer_tag = tags[i-1];
        end else begin : g_no_nearer
            assign nearer_tag = '0;
        end

        if (i < NUM_POS - 1) begin : g_has_farther
            assign farther_tag = tags[i+1];
        end else begin : g_no_farther
            assign farther_tag = '0;
        end

        always_comb begin
            tag_nxt = tags[i];
            val_nxt = valid[i];
            unique case (op)
                OP_HIT: begin
                    if (int'(op_pos) == i) begin
                        tag_nxt = nearer_tag;
                    end else if (int'(op_pos) == i + 1) begin
                        tag_nxt = farther_tag;
                    end
                end
                OP_FILL_EMPTY: begin
                    if (int'(fill_pos) == i) begin
                        tag_nxt = fill_tag;
                        val_nxt = 1'b1;
                    end
                end
                OP_FILL_FULL: begin
                    if (i == MID) begin
                        tag_nxt = fill_tag;
                    end else if (i > MID) begin
                        tag_nxt = nearer_tag;
                    end
                end
                default: begin
                    tag_nxt = tags[i];
                end
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[i]  <= '0;
                valid[i] <= 1'b0;
            end else begin
                tags[i]  <= tag_nxt;
                valid[i] <= val_nxt;
            end
        end

        if (i > 0) begin : g_swap_chk
            // R2: promotion trades places with the nearer neighbour
            assert_hit_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_HIT && int'(op_pos) == i) |=>
                (tags[i-1] == $past(tags[i]) && tags[i] == $past(tags[i-1])));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_valid <= 1'b0;
            evict_tag   <= '0;
        end else begin
            evict_valid <= (op == OP_FILL_FULL);
            evict_tag   <= (op == OP_FILL_FULL) ? tags[NUM_POS-1] : evict_tag;
        end
    end

    // R4: insertion into a full set lands at the middle
    assert_mid_insert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FILL_FULL |=> (tags[MID] == $past(fill_tag) && valid == $past(valid)));

    // R5: the farthest line is the one reported
    assert_evict_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FILL_FULL |=> (evict_valid && evict_tag == $past(tags[NUM_POS-1])));

    // R6: filling an empty slot never evicts
    assert_no_evict_on_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FILL_EMPTY |=> !evict_valid);

    // R3 and R8: no operation leaves the set untouched
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_IDLE |=> ($stable(tags) && $stable(valid) && !evict_valid));

endmodule

// File: rtl/promo_bank_set.sv
module promo_bank_set
    import pbs_pkg::*;
#(
    parameter int NUM_POS = 8,
    parameter int TAG_W   = 8,
    localparam int POS_W  = $clog2(NUM_POS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hit_req,
    input  logic [POS_W-1:0]           hit_pos,
    input  logic                       fill_req,
    input  logic [TAG_W-1:0]           fill_tag,
    output logic                       fill_stall,
    output logic                       evict_valid,
    output logic [TAG_W-1:0]           evict_tag,
    output logic [NUM_POS*TAG_W-1:0]   set_tags,
    output logic [NUM_POS-1:0]         set_valid
);

    op_e                          op;
    logic [POS_W-1:0]             op_pos;
    logic [POS_W-1:0]             fill_pos;
    logic [NUM_POS-1:0][TAG_W-1:0] tags;
    logic [NUM_POS-1:0]           valid;

    pbs_op_decode #(
        .NUM_POS (NUM_POS)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_req    (hit_req),
        .hit_pos    (hit_pos),
        .fill_req   (fill_req),
        .slot_valid (valid),
        .op         (op),
        .op_pos     (op_pos),
        .fill_pos   (fill_pos),
        .fill_stall (fill_stall)
    );

    pbs_slot_store #(
        .NUM_POS (NUM_POS),
        .TAG_W   (TAG_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .op_pos      (op_pos),
        .fill_pos    (fill_pos),
        .fill_tag    (fill_tag),
        .tags        (tags),
        .valid       (valid),
        .evict_valid (evict_valid),
        .evict_tag   (evict_tag)
    );

    assign set_tags  = tags;
    assign set_valid = valid;

    // R1: nothing leaves the set in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!evict_valid && set_valid == '0));

endmodule

// File: tb/promo_bank_set_bench.sv
module promo_bank_set_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int TW  = 8;
    localparam int PW  = $clog2(N);
    localparam int MID = N / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hit_req = 1'b0;
    logic [PW-1:0]     hit_pos = '0;
    logic              fill_req = 1'b0;
    logic [TW-1:0]     fill_tag = '0;
    logic              fill_stall;
    logic              evict_valid;
    logic [TW-1:0]     evict_tag;
    logic [N*TW-1:0]   set_tags;
    logic [N-1:0]      set_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [TW-1:0] m_tag [N];
    logic          m_val [N];
    logic          exp_ev;
    logic [TW-1:0] exp_ev_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    promo_bank_set #(.NUM_POS(N), .TAG_W(TW)) u_promo_bank_set (
        .clk(clk), .rst_n(rst_n), .hit_req(hit_req), .hit_pos(hit_pos),
        .fill_req(fill_req), .fill_tag(fill_tag), .fill_stall(fill_stall),
        .evict_valid(evict_valid), .evict_tag(evict_tag),
        .set_tags(set_tags), .set_valid(set_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N*TW-1:0] pack_tags();
        logic [N*TW-1:0] v;
        for (int j = 0; j < N; j++) v[j*TW +: TW] = m_tag[j];
        return v;
    endfunction

    function automatic logic [N-1:0] pack_val();
        logic [N-1:0] v;
        for (int j = 0; j < N; j++) v[j] = m_val[j];
        return v;
    endfunction

    // expected-state update from the requirements; returns the requirement tag
    function automatic string model_step(input logic h, input int hp, input logic f, input logic [TW-1:0] ft);
        int cnt;
        logic [TW-1:0] t;
        exp_ev = 1'b0;
        if (h) begin
            if (hp > 0 && m_val[hp] && m_val[hp-1]) begin
                t = m_tag[hp]; m_tag[hp] = m_tag[hp-1]; m_tag[hp-1] = t;
                return "R2";
            end
            return "R3";
        end else if (f) begin
            cnt = 0;
            for (int j = 0; j < N; j++) if (m_val[j]) cnt++;
            if (cnt < N) begin
                m_tag[N-1-cnt] = ft; m_val[N-1-cnt] = 1'b1;
                return "R6";
            end
            exp_ev = 1'b1;
            exp_ev_tag = m_tag[N-1];
            for (int j = N-1; j > MID; j--) m_tag[j] = m_tag[j-1];
            m_tag[MID] = ft;
            return "R4";
        end
        return "R8";
    endfunction

    // called just after a falling edge
    task automatic step(input logic h, input int hp, input logic f, input logic [TW-1:0] ft);
        string req;
        hit_req = h; hit_pos = PW'(hp); fill_req = f; fill_tag = ft;
        #1;
        check(fill_stall == (h && f), "R7", 64'(fill_stall), 64'(h && f));
        @(posedge clk);
        #1;
        req = model_step(h, hp, f, ft);
        if (h && f) req = {req, "/R7"};
        check(set_tags == pack_tags(), req, set_tags, pack_tags());
        check(set_valid == pack_val(), req, 64'(set_valid), 64'(pack_val()));
        check(evict_valid == exp_ev, "R5", 64'(evict_valid), 64'(exp_ev));
        if (exp_ev) check(evict_tag == exp_ev_tag, "R5", 64'(evict_tag), 64'(exp_ev_tag));
        @(negedge clk);
        hit_req = 1'b0; fill_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd20240611));
        for (int j = 0; j < N; j++) begin m_tag[j] = '0; m_val[j] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(set_valid == '0, "R1", 64'(set_valid), 64'd0);
        check(set_tags == '0, "R1", set_tags, 64'd0);
        check(!evict_valid, "R1", 64'(evict_valid), 64'd0);
        check(!fill_stall, "R1", 64'(fill_stall), 64'd0);
        @(negedge clk);

        step(1'b1, 3, 1'b0, 8'h00);          // R3: hit on empty slot
        step(1'b0, 0, 1'b0, 8'h00);          // R8: idle
        for (int k = 0; k < N; k++) begin
            step(1'b0, 0, 1'b1, TW'(8'h10 + k));  // R6: fill farthest-first
            if (k == 0) check(set_tags[(N-1)*TW +: TW] == 8'h10, "R9",
                              64'(set_tags[(N-1)*TW +: TW]), 64'h10);
        end
        step(1'b1, 0, 1'b0, 8'h00);          // R3: hit at position 0
        step(1'b1, 5, 1'b0, 8'h00);          // R2: promote 5 -> 4
        step(1'b0, 0, 1'b1, 8'hA5);          // R4/R5: full insert
        step(1'b0, 0, 1'b0, 8'h00);          // R5: pulse ends
        step(1'b1, 2, 1'b1, 8'hEE);          // R7: hit wins, fill stalled
        step(1'b0, 0, 1'b1, 8'hB6);          // R4/R5: retry

        for (int k = 0; k < 2500; k++) begin
            r = int'($urandom % 8);
            unique case (r)
                0, 1, 2: step(1'b1, int'($urandom % N), 1'b0, 8'h00);
                3, 4:    step(1'b0, 0, 1'b1, TW'($urandom));
                5:       step(1'b1, int'($urandom % N), 1'b1, TW'($urandom));
                default: step(1'b0, 0, 1'b0, 8'h00);
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule